// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Command Decoder

This block takes 24-bit command words that a serial front end has already collected. It keeps the register state for two output channels, A and B. Each channel has two stages. The first is a staging buffer that a command writes into. The second is an active register whose contents the block drives out. Both stages hold a 16-bit code and a 2-bit power mode. A command names one buffer to write. It can also, on its own flags, copy either buffer or both into the matching active registers. This lets a host update the two channels one after the other, or update them together from a single command. Power-down works the same way.

Commands arrive on a valid/ready stream. `cmd_ready` is low while reset is asserted and then stays high, so the block never applies back-pressure. A word is taken on every rising clock edge where `cmd_valid` and `cmd_ready` are both high. The whole effect of that word is visible on the outputs right after that edge. A word offered while `cmd_ready` is low is not taken.

Command word fields:
- [23:22] reserved, must be 00.
- [21] load channel B.
- [20] load channel A.
- [19] unused.
- [18] destination buffer (0 = A, 1 = B).
- [17:16] power mode.
- [15:0] code.

Top module: `dual_chan_cmd_decoder`

## Requirements
- R1: After reset, both active codes read 0 and both active modes read 00. Both power-down indicators and `rsv_err` read 0. `cmd_ready` rises at the first clock edge after reset is released.
- R2: A word is taken only on an edge where `cmd_valid` and `cmd_ready` are both high. Its effect appears on the outputs right after that edge. With `cmd_valid` low the outputs hold.
- R3: A taken word whose bits [23:22] are not 00 changes no buffer and no active register, even when its load bits are set. It sets `rsv_err`, which stays high until reset.
- R4: Bit [18] selects the buffer to write: 0 writes buffer A and 1 writes buffer B. A word with bits [21:20] = 00 changes no output.
- R5: Bit [20] copies buffer A into active A, and bit [21] copies buffer B into active B. With both bits set, both channels change on the same edge. A channel whose load bit is clear holds its active state.
- R6: Within one word, the buffer write happens before the loads. A load of the channel that the same word writes uses the newly written code and mode.
- R7: Bits [17:16] give the mode: 00 normal, 01 low-ohm pulldown, 10 high-ohm pulldown, 11 open output. The active mode appears on `mode_a`/`mode_b`. `pd_a`/`pd_b` are 1 exactly when that mode is not 00.
- R8: A buffer write with a nonzero mode stores the mode and keeps the buffer's old code, so bits [15:0] are ignored. Loading a nonzero mode keeps the channel's previous active code.
- R9: A powered-down channel returns to mode 00 only when a word with mode 00 and a new code is written to its buffer and that channel is then loaded. The code then becomes active.
- R10: Bit [19] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Block accepts a word this cycle |
| cmd_word | input | 24 | Command word |
| code_a | output | 16 | Active code of channel A |
| mode_a | output | 2 | Active power mode of channel A |
| pd_a | output | 1 | Channel A is powered down |
| code_b | output | 16 | Active code of channel B |
| mode_b | output | 2 | Active power mode of channel B |
| pd_b | output | 1 | Channel B is powered down |
| rsv_err | output | 1 | Sticky: a word with nonzero reserved bits was seen |

## Verification
The bench goes after several corner cases:
- A word that writes buffer B and loads both channels. A design that loads before it writes would drive the old B code.
- A power-down load followed by a return to normal. A design that copies the ignored data field would lose the held code, and one that drops the code on power-down would come back with the wrong code.
- Reserved-bit words that also carry load flags. A design that partly honours them would move an output, or would show a changed buffer on a later load.
- Toggling the unused bit, and seeded random words against a reference model. These expose any field confusion, such as a swapped select or load bit.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int CODE_W_DEF = 16;
  localparam int MODE_W     = 2;

  localparam logic [MODE_W-1:0] PM_ON   = 2'b00;
  localparam logic [MODE_W-1:0] PM_LOW  = 2'b01;
  localparam logic [MODE_W-1:0] PM_HIGH = 2'b10;
  localparam logic [MODE_W-1:0] PM_OPEN = 2'b11;

  // bit offsets counted from the code width
  function automatic int sel_pos(input int cw);  return cw + 2; endfunction
  function automatic int lda_pos(input int cw);  return cw + 4; endfunction
  function automatic int ldb_pos(input int cw);  return cw + 5; endfunction
  function automatic int rsv_top(input int cw);  return cw + 7; endfunction
endpackage

// File: rtl/dcd_cmd_fields.sv
module dcd_cmd_fields #(
  parameter int CODE_W = dcd_pkg::CODE_W_DEF,
  localparam int CMD_W = CODE_W + 8
) (
  input  logic                      take,
  input  logic [CMD_W-1:0]          word,
  output logic                      rsv_bad,
  output logic [1:0]                wr_en,
  output logic [1:0]                ld_en,
  output logic [dcd_pkg::MODE_W-1:0] wr_mode,
  output logic [CODE_W-1:0]         wr_code
);
  localparam int SEL = dcd_pkg::sel_pos(CODE_W);
  localparam int LDA = dcd_pkg::lda_pos(CODE_W);
  localparam int LDB = dcd_pkg::ldb_pos(CODE_W);
  localparam int RSV = dcd_pkg::rsv_top(CODE_W);

  logic ok;

  always_comb begin
    rsv_bad = take && (word[RSV -: 2] != 2'b00);
    ok      = take && (word[RSV -: 2] == 2'b00);
    wr_en   = 2'b00;
    if (ok) wr_en[word[SEL]] = 1'b1;
    ld_en   = ok ? {word[LDB], word[LDA]} : 2'b00;
    wr_mode = word[CODE_W +: dcd_pkg::MODE_W];
    wr_code = word[CODE_W-1:0];
  end
endmodule

// File: rtl/dcd_chan.sv
module dcd_chan #(
  parameter int CODE_W = dcd_pkg::CODE_W_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       ld_en,
  input  logic [dcd_pkg::MODE_W-1:0] wr_mode,
  input  logic [CODE_W-1:0]          wr_code,
  output logic [CODE_W-1:0]          act_code,
  output logic [dcd_pkg::MODE_W-1:0] act_mode,
  output logic                       pd
);
  import dcd_pkg::*;

  logic [CODE_W-1:0] buf_code, buf_code_nx;
  logic [MODE_W-1:0] buf_mode, buf_mode_nx;

  // write stage resolves first so a same-word load sees it
  always_comb begin
    buf_mode_nx = wr_en ? wr_mode : buf_mode;
    buf_code_nx = (wr_en && wr_mode == PM_ON) ? wr_code : buf_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_code <= '0;
      buf_mode <= PM_ON;
      act_code <= '0;
      act_mode <= PM_ON;
    end else begin
      buf_code <= buf_code_nx;
      buf_mode <= buf_mode_nx;
      if (ld_en) begin
        act_mode <= buf_mode_nx;
        if (buf_mode_nx == PM_ON) act_code <= buf_code_nx;
      end
    end
  end

  assign pd = (act_mode != PM_ON);

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> ($stable(act_code) && $stable(act_mode))); // R5
  AST_PD_CODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && wr_en && wr_mode != PM_ON) |=> $stable(act_code)); // R8
  AST_WAKE_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && !ld_en) |=> pd); // R9
endmodule

// File: rtl/dual_chan_cmd_decoder.sv
module dual_chan_cmd_decoder #(
  parameter int CODE_W = dcd_pkg::CODE_W_DEF,
  localparam int CMD_W = CODE_W + 8,
  localparam int MW    = dcd_pkg::MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic [CODE_W-1:0] code_a,
  output logic [MW-1:0]     mode_a,
  output logic              pd_a,
  output logic [CODE_W-1:0] code_b,
  output logic [MW-1:0]     mode_b,
  output logic              pd_b,
  output logic              rsv_err
);
  logic              take, rsv_bad;
  logic [1:0]        wr_en, ld_en, pd_v;
  logic [MW-1:0]     wr_mode;
  logic [CODE_W-1:0] wr_code;
  logic [CODE_W-1:0] code_v [2];
  logic [MW-1:0]     mode_v [2];

  assign take = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ready <= 1'b0;
      rsv_err   <= 1'b0;
    end else begin
      cmd_ready <= 1'b1;
      if (rsv_bad) rsv_err <= 1'b1;
    end
  end

  dcd_cmd_fields #(.CODE_W(CODE_W)) u_fields (
    .take(take), .word(cmd_word), .rsv_bad(rsv_bad), .wr_en(wr_en),
    .ld_en(ld_en), .wr_mode(wr_mode), .wr_code(wr_code)
  );

  for (genvar c = 0; c < 2; c++) begin : g_ch
    dcd_chan #(.CODE_W(CODE_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en[c]), .ld_en(ld_en[c]),
      .wr_mode(wr_mode), .wr_code(wr_code),
      .act_code(code_v[c]), .act_mode(mode_v[c]), .pd(pd_v[c])
    );
  end

  assign code_a = code_v[0];
  assign mode_a = mode_v[0];
  assign pd_a   = pd_v[0];
  assign code_b = code_v[1];
  assign mode_b = mode_v[1];
  assign pd_b   = pd_v[1];

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_err |=> rsv_err); // R3
  AST_RSV_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_word[CMD_W-1 -: 2] != 2'b00) |=>
      ($stable(code_a) && $stable(code_b) && $stable(mode_a) && $stable(mode_b))); // R3
  AST_ONE_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(code_a) && $stable(code_b) && $stable(mode_a) && $stable(mode_b))); // R2
endmodule

// File: tb/sim_dual_chan_cmd_decoder.sv
module sim_dual_chan_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [23:0] cmd_word = '0;
  logic cmd_ready, pd_a, pd_b, rsv_err;
  logic [15:0] code_a, code_b;
  logic [1:0] mode_a, mode_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model
  logic [15:0] m_bcode [2];
  logic [1:0]  m_bmode [2];
  logic [15:0] m_acode [2];
  logic [1:0]  m_amode [2];
  logic        m_err;

  always #5 clk = ~clk;

  dual_chan_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .code_a(code_a), .mode_a(mode_a), .pd_a(pd_a),
    .code_b(code_b), .mode_b(mode_b), .pd_b(pd_b), .rsv_err(rsv_err)
  );

  function automatic logic [23:0] mk(input bit [1:0] rsv, input bit ldb, input bit lda,
                                     input bit dc, input bit sel, input bit [1:0] pm,
                                     input bit [15:0] d);
    return {rsv, ldb, lda, dc, sel, pm, d};
  endfunction

  task automatic model_apply(input logic [23:0] w);
    int s;
    if (w[23:22] != 2'b00) begin
      m_err = 1'b1;
      return;
    end
    s = w[18];
    m_bmode[s] = w[17:16];
    if (w[17:16] == 2'b00) m_bcode[s] = w[15:0];
    for (int c = 0; c < 2; c++) begin
      if (w[20 + c]) begin
        m_amode[c] = m_bmode[c];
        if (m_bmode[c] == 2'b00) m_acode[c] = m_bcode[c];
      end
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "code_a", {16'h0, code_a}, {16'h0, m_acode[0]});
    chk(req, "code_b", {16'h0, code_b}, {16'h0, m_acode[1]});
    chk(req, "mode_a", {30'h0, mode_a}, {30'h0, m_amode[0]});
    chk(req, "mode_b", {30'h0, mode_b}, {30'h0, m_amode[1]});
    chk(req, "pd_a R7", {31'h0, pd_a}, {31'h0, (m_amode[0] != 2'b00)});
    chk(req, "pd_b R7", {31'h0, pd_b}, {31'h0, (m_amode[1] != 2'b00)});
    chk(req, "rsv_err", {31'h0, rsv_err}, {31'h0, m_err});
  endtask

  task automatic send(input logic [23:0] w, input string req);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_apply(w);
    chk_all(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int c = 0; c < 2; c++) begin
      m_bcode[c] = '0; m_bmode[c] = '0; m_acode[c] = '0; m_amode[c] = '0;
    end
    m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state and ready
    chk("R1", "cmd_ready", {31'h0, cmd_ready}, 32'h1);
    chk_all("R1");

    // R2 a word offered with valid low is not taken
    @(negedge clk);
    cmd_word = mk(0, 1, 1, 0, 0, 0, 16'hDEAD);
    @(negedge clk);
    chk_all("R2");

    // R4 buffer write without load changes nothing; select picks buffer
    send(mk(0, 0, 0, 0, 0, 2'b00, 16'h1111), "R4");
    send(mk(0, 0, 0, 0, 1, 2'b00, 16'h2222), "R4");
    // R5 load A only, then B only
    send(mk(0, 0, 1, 0, 0, 2'b00, 16'h1234), "R5");
    chk("R5", "code_a", {16'h0, code_a}, 32'h1234);
    chk("R5", "code_b", {16'h0, code_b}, 32'h0);
    send(mk(0, 1, 0, 0, 0, 2'b00, 16'h0001), "R5");
    chk("R5", "code_b", {16'h0, code_b}, 32'h2222);
    // R6 write B and load both in one word
    send(mk(0, 0, 0, 0, 0, 2'b00, 16'hAAAA), "R6");
    send(mk(0, 1, 1, 0, 1, 2'b00, 16'hBBBB), "R6");
    chk("R6", "code_b", {16'h0, code_b}, 32'hBBBB);
    chk("R6", "code_a", {16'h0, code_a}, 32'hAAAA);
    // R10 unused bit set
    send(mk(0, 0, 1, 1, 0, 2'b00, 16'h5A5A), "R10");
    chk("R10", "code_a", {16'h0, code_a}, 32'h5A5A);
    // R7 R8 power-down of both with different modes, codes kept
    send(mk(0, 0, 0, 0, 0, 2'b01, 16'hFFFF), "R8");
    send(mk(0, 1, 1, 0, 1, 2'b10, 16'h7777), "R7");
    chk("R8", "code_a", {16'h0, code_a}, 32'h5A5A);
    chk("R8", "code_b", {16'h0, code_b}, 32'hBBBB);
    chk("R7", "mode_a", {30'h0, mode_a}, 32'h1);
    chk("R7", "mode_b", {30'h0, mode_b}, 32'h2);
    send(mk(0, 0, 1, 0, 0, 2'b11, 16'h0F0F), "R7");
    chk("R7", "mode_a", {30'h0, mode_a}, 32'h3);
    // R9 reload without new write stays down; exit with mode 00 write + load
    send(mk(0, 1, 0, 0, 0, 2'b11, 16'h0000), "R9");
    chk("R9", "pd_b", {31'h0, pd_b}, 32'h1);
    send(mk(0, 1, 0, 0, 1, 2'b00, 16'h4321), "R9");
    chk("R9", "pd_b", {31'h0, pd_b}, 32'h0);
    chk("R9", "code_b", {16'h0, code_b}, 32'h4321);
    // R3 reserved bits: ignored, sticky error, buffers untouched
    send(mk(2'b10, 1, 1, 0, 0, 2'b00, 16'h9999), "R3");
    send(mk(2'b01, 1, 1, 0, 1, 2'b00, 16'h8888), "R3");
    chk("R3", "rsv_err", {31'h0, rsv_err}, 32'h1);
    send(mk(0, 1, 0, 0, 0, 2'b00, 16'h0000), "R3");
    chk("R3", "code_b", {16'h0, code_b}, 32'h4321);

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [23:0] w;
      w = 24'($urandom);
      if (($urandom % 16) != 0) w[23:22] = 2'b00;
      send(w, "R2");
    end

    // R1 reset clears again
    do_reset();
    chk_all("R1");
    finish_run();
  end
endmodule